// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, A and B, and passes data between them in either direction. Each direction has its own holding register and its own rising-edge clock. The A-side register captures the A bus, and the B-side register captures the B bus. An active-low enable and a direction input decide which bus, if any, the block drives.

Each bus appears as three port groups: incoming data, outgoing data and an output-enable flag. The surrounding logic resolves the physical pin, so the block needs no tristate primitive. A driven output shows one of two sources, picked by that direction's select: the live data from the opposite bus, or the register that holds data from the opposite bus. A parameter chooses between a non-inverting and an inverting output stage.

The registers keep capturing while both outputs are disabled, so the block can hold one word from each bus in isolation. Each register samples the resolved value of its bus. On a bus the block is driving, this is the value the block drives onto it.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_ni is low, both holding registers clear to zero. After release, a driven output with stored data selected reads zero in the non-inverting variant and all ones in the inverting variant.
- R2: On a rising edge of clk_ab_i, the A-side register loads the resolved A bus. On a rising edge of clk_ba_i, the B-side register loads the resolved B bus. Each register keeps its value between its own clock edges.
- R3: When en_ni is 1, a_oe_o and b_oe_o are both 0 and a_o and b_o are both all zeros.
- R4: With en_ni = 0, dir_i = 1 drives B (b_oe_o = 1, a_oe_o = 0), and dir_i = 0 drives A (a_oe_o = 1, b_oe_o = 0).
- R5: While B is driven, sel_ab_i = 0 makes b_o follow a_i combinationally, with no clock needed. sel_ab_i = 1 makes b_o show the A-side register.
- R6: While A is driven, sel_ba_i = 0 makes a_o follow b_i combinationally. sel_ba_i = 1 makes a_o show the B-side register.
- R7: With en_ni = 1 (isolation), both registers still capture from a_i and b_i on their clock edges.
- R8: a_oe_o and b_oe_o are never both 1.
- R9: With INVERT = 1, every driven output bit is the complement of the selected source. The register contents themselves are not complemented.
- R10: The resolved value of a driven bus is the block's own output on that bus. A clock edge for that bus's register therefore loads what the block is driving.
- R11: While live data passes through, a clock edge in the same direction stores that same live word. The stored word stays visible after the source changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab_i | input | 1 | Capture clock for the A-side register, rising edge |
| clk_ba_i | input | 1 | Capture clock for the B-side register, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset for both registers |
| en_ni | input | 1 | Active-low output enable |
| dir_i | input | 1 | 1: drive B, 0: drive A |
| sel_ab_i | input | 1 | Source for B: 0 live A, 1 A-side register |
| sel_ba_i | input | 1 | Source for A: 0 live B, 1 B-side register |
| a_i | input | WIDTH | Data arriving from bus A |
| a_o | output | WIDTH | Data the block drives onto bus A |
| a_oe_o | output | 1 | Block is driving bus A |
| b_i | input | WIDTH | Data arriving from bus B |
| b_o | output | WIDTH | Data the block drives onto bus B |
| b_oe_o | output | 1 | Block is driving bus B |

## Verification
All sixteen combinations of enable, direction and the two selects are swept, each with a different data word on each bus. Outputs are compared against a mode-table model before and after each capture edge, which separates the live path from the stored path and shows which register each clock loads. Dedicated cases change live data with no clock edge (combinational pass-through), capture while in isolation, and capture on a bus the block is driving (the register must take the driven word, not a_i or b_i). A non-inverting and an inverting instance run side by side on the same stimulus, so complementing the register contents is distinguished from complementing only the output.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic   en_ni,
  input  logic   dir_i,
  output drive_e drv_o
);
  always_comb begin
    if (en_ni)      drv_o = DRV_NONE;
    else if (dir_i) drv_o = DRV_B;
    else            drv_o = DRV_A;
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> q_o == $past(d_i));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  input  logic             sel_i,
  input  logic             drive_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] staged;

  assign src = sel_i ? stored_i : live_i;

  generate
    if (INVERT) begin : g_inv
      assign staged = ~src;
    end else begin : g_pass
      assign staged = src;
    end
  endgenerate

  // quiet zeros when not driving keeps downstream muxing deterministic
  assign data_o = drive_i ? staged : '0;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  drive_e           drv;
  logic [WIDTH-1:0] reg_a, reg_b;
  logic [WIDTH-1:0] res_a, res_b;

  xcvr_ctrl u_ctrl (
    .en_ni (en_ni),
    .dir_i (dir_i),
    .drv_o (drv)
  );

  assign a_oe_o = (drv == DRV_A);
  assign b_oe_o = (drv == DRV_B);

  // registers see the resolved pin: own drive wins when enabled
  assign res_a = a_oe_o ? a_o : a_i;
  assign res_b = b_oe_o ? b_o : b_i;

  xcvr_store #(.WIDTH(WIDTH)) u_reg_a (
    .clk_i  (clk_ab_i),
    .rst_ni (rst_ni),
    .d_i    (res_a),
    .q_o    (reg_a)
  );

  xcvr_store #(.WIDTH(WIDTH)) u_reg_b (
    .clk_i  (clk_ba_i),
    .rst_ni (rst_ni),
    .d_i    (res_b),
    .q_o    (reg_b)
  );

  xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
    .live_i   (a_i),
    .stored_i (reg_a),
    .sel_i    (sel_ab_i),
    .drive_i  (b_oe_o),
    .data_o   (b_o)
  );

  xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
    .live_i   (b_i),
    .stored_i (reg_b),
    .sel_i    (sel_ba_i),
    .drive_i  (a_oe_o),
    .data_o   (a_o)
  );

  assert_one_driver_R8: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  assert_isolated_quiet_R3: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    en_ni |-> (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0));

  assert_b_live_R5: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ni && dir_i && !sel_ab_i) |-> (b_oe_o && b_o == (a_i ^ FLIP)));

  assert_a_live_R6: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (!en_ni && !dir_i && !sel_ba_i) |-> (a_oe_o && a_o == (b_i ^ FLIP)));

  assert_dir_pick_R4: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !en_ni |-> (b_oe_o == dir_i && a_oe_o == !dir_i));
endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic         en_n = 1'b1, dir = 1'b0, sab = 1'b0, sba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_n, b_n, a_v, b_v;
  logic         aoe_n, boe_n, aoe_v, boe_v;

  int n_tests = 0;
  int n_fail  = 0;

  // model registers: _n non-inverting, _v inverting
  logic [W-1:0] ra_n = '0, rb_n = '0, ra_v = '0, rb_v = '0;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) dut (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .en_ni(en_n), .dir_i(dir), .sel_ab_i(sab), .sel_ba_i(sba),
    .a_i(a_in), .a_o(a_n), .a_oe_o(aoe_n),
    .b_i(b_in), .b_o(b_n), .b_oe_o(boe_n));

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) dut_inv (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .en_ni(en_n), .dir_i(dir), .sel_ab_i(sab), .sel_ba_i(sba),
    .a_i(a_in), .a_o(a_v), .a_oe_o(aoe_v),
    .b_i(b_in), .b_o(b_v), .b_oe_o(boe_v));

  // {a_oe, b_oe, a_o, b_o} from the mode table
  function automatic logic [2*W+1:0] expect_out(bit inv, logic [W-1:0] ra, logic [W-1:0] rb);
    logic oa, ob;
    logic [W-1:0] xa, xb;
    oa = !en_n && !dir;
    ob = !en_n && dir;
    xa = sba ? rb : b_in;
    xb = sab ? ra : a_in;
    if (inv) begin xa = ~xa; xb = ~xb; end
    if (!oa) xa = '0;
    if (!ob) xb = '0;
    return {oa, ob, xa, xb};
  endfunction

  task automatic check(input string tag);
    logic [2*W+1:0] en_exp, ev_exp, en_act, ev_act;
    en_exp = expect_out(1'b0, ra_n, rb_n);
    ev_exp = expect_out(1'b1, ra_v, rb_v);
    en_act = {aoe_n, boe_n, a_n, b_n};
    ev_act = {aoe_v, boe_v, a_v, b_v};
    n_tests += 2;
    if (en_act !== en_exp) begin
      n_fail++;
      $display("FAIL %s plain: got %h exp %h", tag, en_act, en_exp);
    end
    if (ev_act !== ev_exp) begin
      n_fail++;
      $display("FAIL %s invert: got %h exp %h", tag, ev_act, ev_exp);
    end
  endtask

  task automatic set_mode(input logic e, input logic d, input logic s1, input logic s2,
                          input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    en_n = e; dir = d; sab = s1; sba = s2; a_in = a; b_in = b;
    #1;
  endtask

  task automatic pulse(input bit do_ab, input bit do_ba);
    logic [2*W+1:0] on, ov;
    @(negedge clk);
    on = expect_out(1'b0, ra_n, rb_n);
    ov = expect_out(1'b1, ra_v, rb_v);
    if (do_ab) begin
      ra_n = on[2*W+1] ? on[2*W-1:W] : a_in;
      ra_v = ov[2*W+1] ? ov[2*W-1:W] : a_in;
    end
    if (do_ba) begin
      rb_n = on[2*W] ? on[W-1:0] : b_in;
      rb_v = ov[2*W] ? ov[W-1:0] : b_in;
    end
    clk_ab = do_ab;
    clk_ba = do_ba;
    #2;
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #1;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    set_mode(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hA5);
    check("R1");
    set_mode(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hA5);
    check("R1");
  endtask

  task automatic test_isolation();
    set_mode(1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3);
    check("R3");
    pulse(1'b1, 1'b1);
    check("R7");
    set_mode(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF);
    check("R3");
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF);
    check("R7");
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF);
    check("R7");
  endtask

  task automatic test_live_ab();
    set_mode(1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h00);
    check("R4");
    set_mode(1'b0, 1'b1, 1'b0, 1'b0, 8'h7E, 8'h00);
    check("R5");
    pulse(1'b1, 1'b0);
    set_mode(1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h00);
    check("R5");
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'h22, 8'h00);
    check("R11");
  endtask

  task automatic test_live_ba();
    set_mode(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h96);
    check("R4");
    set_mode(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h69);
    check("R6");
    pulse(1'b0, 1'b1);
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hF0);
    check("R11");
  endtask

  task automatic test_driven_capture();
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'hE7, 8'h18);
    pulse(1'b1, 1'b0);
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'hE7, 8'h18);
    check("R10");
    pulse(1'b0, 1'b1);
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    check("R10");
  endtask

  task automatic test_invert();
    set_mode(1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h0F);
    pulse(1'b1, 1'b1);
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    check("R9");
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    check("R9");
  endtask

  task automatic test_sweep();
    for (int i = 0; i < 16; i++) begin
      set_mode(i[3], i[2], i[1], i[0], 8'(i * 37 + 11), 8'(~(i * 53)));
      check("R8");
      pulse(1'b1, 1'b0);
      check("R2");
      pulse(1'b0, 1'b1);
      check("R2");
      set_mode(i[3], i[2], i[1], i[0], 8'(i * 91 + 5), 8'(i * 19 + 200));
      check("R4");
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_isolation();
    test_live_ab();
    test_live_ba();
    test_driven_capture();
    test_invert();
    test_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule